// File: doc/BRIEF.md
# Cartridge Bank and Save-RAM Mapper

This block sits between a CPU's 24-bit cartridge address bus and the external ROM and save RAM. It translates each cartridge access into a physical ROM word address or a save RAM word address. The cartridge space is split into eight 512 KB slots, and each slot takes its ROM bank number from a 6-bit register. Slot 0 always maps to bank 0. The other seven slots can be reassigned at run time, which lets the CPU reach ROM images larger than its 4 MB cartridge window.

When save RAM is fitted and enabled, it overlays every cartridge address that has bit 21 set. The RAM address is the CPU address truncated to the RAM size. A small register window at 0xA130xx holds the mapper controls. The odd addresses 0xA130F1 through 0xA130FF are decoded, and everything else in the window has no effect.

All access outputs are combinational from the request. A register write takes effect on the clock edge that accepts it, so the next access already uses the new mapping. Word data is big-endian, so the even byte travels on the upper data lane.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, the bank register of slot n holds n for every n from 0 to 7, RAM enable is 1 and the write-protect flag is 1.
- R2: A read below 0x400000 that does not hit RAM asserts `rom_rd`, and `rom_waddr` is {bank of slot addr[21:19], addr[18:1]}.
- R3: When addr[21] is 1 in cartridge space, save RAM is fitted and RAM enable is 1, the access goes to RAM and not to ROM. A read asserts `ram_rd` and a write asserts `ram_wr`, `rom_rd` stays low, and `ram_waddr` is addr[RAM_AW-1:1].
- R4: A write to 0xA130F1 loads RAM enable from data bit 0 and the write-protect flag from data bit 1. With RAM enable at 0, addresses with bit 21 set read ROM through their slot's bank.
- R5: Writes to 0xA130F3, F5, F7, F9, FB, FD and FF load the bank registers of slots 1 to 7 in that order, taking data bits 5:0 and dropping higher bits. The new value applies from the next cycle.
- R6: Slot 0 always maps to bank 0, whatever is written into the register window.
- R7: The write-protect flag is stored and shown on `wp_flag`, but it never blocks RAM writes.
- R8: A read anywhere in 0xA13000–0xA130FF returns 0x0000 on `rd_data` and asserts neither ROM nor RAM strobe.
- R9: Writes to window addresses other than the eight decoded odd ones (even addresses, or odd addresses below 0xA130F1) change no register.
- R10: RAM byte lanes are big-endian. A word write enables both lanes (`ram_be`=11). A byte write to an even address enables only the upper lane (10), and one to an odd address only the lower lane (01), with the data byte placed on both lanes.
- R11: Writes to ROM space, and any access outside both cartridge space and the register window, assert no strobe. Such reads return 0x0000.
- R12: `rd_data` carries `ram_rdata` on a RAM read and `rom_rdata` on a ROM read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | An access is present this cycle |
| acc_we | input | 1 | 1 for write, 0 for read |
| acc_byte | input | 1 | 1 for byte access, 0 for word access |
| acc_addr | input | 24 | CPU byte address |
| acc_wdata | input | 16 | Write data (a byte access uses bits 7:0) |
| rom_rdata | input | 16 | Word read from the ROM |
| ram_rdata | input | 16 | Word read from the save RAM |
| rom_rd | output | 1 | ROM read strobe |
| rom_waddr | output | 24 | Physical ROM word address |
| ram_rd | output | 1 | Save RAM read strobe |
| ram_wr | output | 1 | Save RAM write strobe |
| ram_waddr | output | RAM_AW-1 | Save RAM word address |
| ram_be | output | 2 | RAM byte enables, bit 1 = even (upper) byte |
| ram_wdata | output | 16 | RAM write data |
| rd_data | output | 16 | Read data returned to the CPU |
| wp_flag | output | 1 | Stored write-protect setting |

## Verification
The hardest state to reach from the ports is a mapping in which slots 4 to 7 are visible as ROM. After reset those slots are covered by the RAM overlay, so their bank registers cannot be seen until RAM enable has been cleared through the control address. The bench therefore disables RAM first and then reads every slot. It reprograms all seven writable banks with distinct values, including one with bits above bit 5 set. It then writes to near-miss window addresses (even neighbours, and odd addresses below F1) and reads every slot again to show that nothing moved, bank 0 included. Only after that does it re-enable RAM with the protect flag cleared, to show that writes still land.

// File: rtl/cart_bank_mapper_pkg.sv
package cart_bank_mapper_pkg;

    localparam int BANK_W     = 6;
    localparam int NUM_SLOTS  = 8;
    localparam int SLOT_SEL_W = $clog2(NUM_SLOTS);
    localparam int SLOT_OFS_W = 19;
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 16;
    localparam int ROM_WAW    = BANK_W + SLOT_OFS_W - 1;
    localparam logic [15:0] WIN_PAGE = 16'hA130;

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_ROM,
        RGN_RAM,
        RGN_WIN
    } region_e;

    typedef struct packed {
        logic                  hit;
        logic                  is_ctrl;
        logic [SLOT_SEL_W-1:0] slot;
    } regsel_t;

    function automatic logic in_cart(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ADDR_W-2] == 2'b00;
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:8] == WIN_PAGE;
    endfunction

    // Decoded registers sit on odd bytes of the top row of the window.
    function automatic regsel_t decode_window(input logic [ADDR_W-1:0] a);
        regsel_t s;
        s.hit     = in_window(a) && (a[7:4] == 4'hF) && a[0];
        s.slot    = a[SLOT_SEL_W:1];
        s.is_ctrl = (a[SLOT_SEL_W:1] == '0);
        return s;
    endfunction

    function automatic logic [1:0] lane_enables(input logic is_byte, input logic odd);
        if (!is_byte) return 2'b11;
        return odd ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_mapper_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_stb,
    input  regsel_t                       sel,
    input  bank_t                         wdata,
    output logic [NUM_SLOTS*BANK_W-1:0]   bank_flat,
    output logic                          ram_en,
    output logic                          ram_wp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_en <= 1'b1;
            ram_wp <= 1'b1;
        end else if (wr_stb && sel.is_ctrl) begin
            ram_en <= wdata[0];
            ram_wp <= wdata[1];
        end
    end

    // Slot 0 has no storage: it is tied to bank 0.
    assign bank_flat[BANK_W-1:0] = '0;

    for (genvar g = 1; g < NUM_SLOTS; g++) begin : g_bank
        bank_t bank_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= BANK_W'(g);
            end else if (wr_stb && !sel.is_ctrl && (sel.slot == SLOT_SEL_W'(g))) begin
                bank_q <= wdata;
            end
        end
        assign bank_flat[g*BANK_W +: BANK_W] = bank_q;
    end

endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
    import cart_bank_mapper_pkg::*;
#(
    parameter int RAM_AW   = 15,
    parameter bit HAS_SRAM = 1'b1
) (
    input  logic                        acc_req,
    input  logic                        acc_we,
    input  logic                        acc_byte,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [DATA_W-1:0]           acc_wdata,
    input  logic [NUM_SLOTS*BANK_W-1:0] bank_flat,
    input  logic                        ram_en,
    output region_e                     region,
    output logic                        rom_rd,
    output logic [ROM_WAW-1:0]          rom_waddr,
    output logic                        ram_rd,
    output logic                        ram_wr,
    output logic [RAM_AW-2:0]           ram_waddr,
    output logic [1:0]                  ram_be,
    output logic [DATA_W-1:0]           ram_wdata
);

    logic                  ram_ok;
    logic                  ram_hit;
    logic [SLOT_SEL_W-1:0] slot;
    bank_t                 bank;

    if (HAS_SRAM) begin : g_sram
        assign ram_ok = ram_en;
    end else begin : g_nosram
        assign ram_ok = 1'b0;
    end

    always_comb begin
        ram_hit = in_cart(acc_addr) && acc_addr[21] && ram_ok;
        if (in_cart(acc_addr))        region = ram_hit ? RGN_RAM : RGN_ROM;
        else if (in_window(acc_addr)) region = RGN_WIN;
        else                          region = RGN_NONE;

        slot      = acc_addr[SLOT_OFS_W +: SLOT_SEL_W];
        bank      = bank_flat[int'(slot)*BANK_W +: BANK_W];
        rom_waddr = {bank, acc_addr[SLOT_OFS_W-1:1]};
        rom_rd    = acc_req && !acc_we && (region == RGN_ROM);

        ram_waddr = acc_addr[RAM_AW-1:1];
        ram_rd    = acc_req && !acc_we && (region == RGN_RAM);
        ram_wr    = acc_req &&  acc_we && (region == RGN_RAM);
        ram_be    = lane_enables(acc_byte, acc_addr[0]);
        ram_wdata = acc_byte ? {acc_wdata[7:0], acc_wdata[7:0]} : acc_wdata;
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_bank_mapper_pkg::*;
#(
    parameter int RAM_AW   = 15,
    parameter bit HAS_SRAM = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_req,
    input  logic               acc_we,
    input  logic               acc_byte,
    input  logic [23:0]        acc_addr,
    input  logic [15:0]        acc_wdata,
    input  logic [15:0]        rom_rdata,
    input  logic [15:0]        ram_rdata,
    output logic               rom_rd,
    output logic [23:0]        rom_waddr,
    output logic               ram_rd,
    output logic               ram_wr,
    output logic [RAM_AW-2:0]  ram_waddr,
    output logic [1:0]         ram_be,
    output logic [15:0]        ram_wdata,
    output logic [15:0]        rd_data,
    output logic               wp_flag
);

    logic [NUM_SLOTS*BANK_W-1:0] bank_flat;
    logic                        ram_en;
    regsel_t                     sel;
    region_e                     region;
    logic                        reg_wr;

    always_comb begin
        sel    = decode_window(acc_addr);
        reg_wr = acc_req && acc_we && sel.hit;
    end

    cart_bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (reg_wr),
        .sel       (sel),
        .wdata     (acc_wdata[BANK_W-1:0]),
        .bank_flat (bank_flat),
        .ram_en    (ram_en),
        .ram_wp    (wp_flag)
    );

    cart_bank_xlate #(
        .RAM_AW   (RAM_AW),
        .HAS_SRAM (HAS_SRAM)
    ) u_xlate (
        .acc_req   (acc_req),
        .acc_we    (acc_we),
        .acc_byte  (acc_byte),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .bank_flat (bank_flat),
        .ram_en    (ram_en),
        .region    (region),
        .rom_rd    (rom_rd),
        .rom_waddr (rom_waddr),
        .ram_rd    (ram_rd),
        .ram_wr    (ram_wr),
        .ram_waddr (ram_waddr),
        .ram_be    (ram_be),
        .ram_wdata (ram_wdata)
    );

    // Window, open bus and writes all read back as zero.
    always_comb begin
        rd_data = '0;
        if (acc_req && !acc_we) begin
            case (region)
                RGN_ROM: rd_data = rom_rdata;
                RGN_RAM: rd_data = ram_rdata;
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
    parameter int RAM_AW = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_req,
    input logic              acc_we,
    input logic              acc_byte,
    input logic [23:0]       acc_addr,
    input logic [15:0]       acc_wdata,
    input logic              rom_rd,
    input logic [23:0]       rom_waddr,
    input logic              ram_rd,
    input logic              ram_wr,
    input logic [RAM_AW-2:0] ram_waddr,
    input logic [1:0]        ram_be,
    input logic [15:0]       rd_data
);

    assert_ram_only_bit21_R3: assert property (@(posedge clk) disable iff (rst)
        (ram_rd || ram_wr) |-> (acc_addr[23:22] == 2'b00 && acc_addr[21] && !rom_rd));

    assert_window_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !acc_we && acc_addr[23:8] == 16'hA130)
            |-> (rd_data == 16'h0000 && !rom_rd && !ram_rd));

    assert_slot0_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (rom_rd && acc_addr[23:19] == 5'd0) |-> (rom_waddr[23:18] == 6'd0));

    assert_bank1_load_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_we && acc_addr == 24'hA130F3)
            |=> ((rom_rd && acc_addr[23:19] == 5'd1) -> (rom_waddr[23:18] == $past(acc_wdata[5:0]))));

    assert_write_no_read_R11: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_we) |-> (!rom_rd && !ram_rd));

    assert_byte_lane_R10: assert property (@(posedge clk) disable iff (rst)
        (ram_wr && acc_byte) |-> ($countones(ram_be) == 1 && ram_be[0] == acc_addr[0]));

    assert_ram_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (ram_rd || ram_wr) |-> (ram_waddr == acc_addr[RAM_AW-1:1]));

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.RAM_AW(RAM_AW)) u_chk (.*);

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;

    localparam int RAM_AW = 15;
    localparam logic [15:0] ROM_PAT = 16'hA55A;
    localparam logic [15:0] RAM_PAT = 16'h3CC3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_req = 1'b0, acc_we = 1'b0, acc_byte = 1'b0;
    logic [23:0]       acc_addr = '0;
    logic [15:0]       acc_wdata = '0;
    logic [15:0]       rom_rdata = ROM_PAT;
    logic [15:0]       ram_rdata = RAM_PAT;
    logic              rom_rd, ram_rd, ram_wr, wp_flag;
    logic [23:0]       rom_waddr;
    logic [RAM_AW-2:0] ram_waddr;
    logic [1:0]        ram_be;
    logic [15:0]       ram_wdata, rd_data;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_bank [8];

    always #10 clk = ~clk;

    cart_bank_mapper #(.RAM_AW(RAM_AW)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present an access at the falling edge; outputs are sampled 5 ns later.
    task automatic access(input logic we, input logic byt, input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        acc_req = 1'b1; acc_we = we; acc_byte = byt; acc_addr = a; acc_wdata = d;
        #5;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0;
    endtask

    task automatic check_rom_slot(input string tag, input int n);
        logic [23:0] a;
        a = (24'(n) << 19) | 24'h02468;
        access(1'b0, 1'b0, a, '0);
        chk({tag, " rom_rd"}, rom_rd, 1);
        chk({tag, " ram_rd"}, ram_rd, 0);
        chk({tag, " rom_waddr"}, rom_waddr, {exp_bank[n], a[18:1]});
        chk({tag, " rd_data"}, rd_data, ROM_PAT);
    endtask

    task automatic t_reset();
        for (int n = 0; n < 4; n++) check_rom_slot("R1 R2 reset slot", n);
        for (int n = 4; n < 8; n++) begin
            access(1'b0, 1'b0, (24'(n) << 19) | 24'h00010, '0);
            chk("R1 reset ram overlay", ram_rd, 1);
        end
        chk("R1 reset wp_flag", wp_flag, 1);
    endtask

    task automatic t_disable_ram();
        access(1'b1, 1'b1, 24'hA130F1, 16'h0002);
        idle();
        chk("R4 wp stored", wp_flag, 1);
        for (int n = 4; n < 8; n++) check_rom_slot("R4 ram off slot", n);
    endtask

    task automatic t_bank_write();
        for (int n = 1; n < 8; n++) begin
            exp_bank[n] = 6'(8'h11 * n + 8'h20);
            access(1'b1, 1'b1, 24'hA130F1 + 24'(2 * n), {8'h00, 8'h11 * 8'(n) + 8'h20});
        end
        idle();
        for (int n = 0; n < 8; n++) check_rom_slot("R5 R6 remap slot", n);
        access(1'b1, 1'b1, 24'hA130F3, 16'h00FF);
        exp_bank[1] = 6'h3F;
        check_rom_slot("R5 six-bit bank", 1);
    endtask

    task automatic t_ignored();
        access(1'b1, 1'b1, 24'hA130F2, 16'h0007);
        access(1'b1, 1'b0, 24'hA130F4, 16'h0707);
        access(1'b1, 1'b1, 24'hA130E3, 16'h0007);
        access(1'b1, 1'b1, 24'hA13001, 16'h0007);
        access(1'b1, 1'b1, 24'hA130F0, 16'h0007);
        idle();
        for (int n = 0; n < 8; n++) check_rom_slot("R9 R6 unchanged slot", n);
    endtask

    task automatic t_ram();
        access(1'b1, 1'b1, 24'hA130F1, 16'h0001);
        idle();
        chk("R7 wp cleared", wp_flag, 0);
        access(1'b0, 1'b0, 24'h20F234, '0);
        chk("R3 ram_rd", ram_rd, 1);
        chk("R3 rom_rd low", rom_rd, 0);
        chk("R3 ram_waddr masked", ram_waddr, 14'h391A);
        chk("R12 ram rd_data", rd_data, RAM_PAT);
        access(1'b1, 1'b0, 24'h301000, 16'hBEEF);
        chk("R7 ram_wr unblocked", ram_wr, 1);
        chk("R10 word be", ram_be, 2'b11);
        chk("R10 word data", ram_wdata, 16'hBEEF);
        access(1'b1, 1'b1, 24'h200010, 16'h005A);
        chk("R10 even byte be", ram_be, 2'b10);
        chk("R10 byte data", ram_wdata, 16'h5A5A);
        access(1'b1, 1'b1, 24'h200011, 16'h00C4);
        chk("R10 odd byte be", ram_be, 2'b01);
        chk("R10 odd byte ram_wr", ram_wr, 1);
        access(1'b1, 1'b1, 24'hA130F1, 16'h0003);
        idle();
        chk("R7 wp set", wp_flag, 1);
        access(1'b1, 1'b0, 24'h2000A0, 16'h1234);
        chk("R7 wr with wp set", ram_wr, 1);
    endtask

    task automatic t_window_and_open();
        access(1'b0, 1'b0, 24'hA130F1, '0);
        chk("R8 window rd_data", rd_data, 0);
        chk("R8 window no rom", rom_rd, 0);
        chk("R8 window no ram", ram_rd, 0);
        access(1'b0, 1'b0, 24'h800000, '0);
        chk("R11 open rd_data", rd_data, 0);
        chk("R11 open no strobe", {rom_rd, ram_rd, ram_wr}, 0);
        access(1'b1, 1'b0, 24'h000100, 16'hFFFF);
        chk("R11 rom write no strobe", {rom_rd, ram_rd, ram_wr}, 0);
        access(1'b1, 1'b0, 24'hE00000, 16'hFFFF);
        chk("R11 outside write no strobe", {rom_rd, ram_rd, ram_wr}, 0);
        idle();
    endtask

    initial begin
        for (int n = 0; n < 8; n++) exp_bank[n] = 6'(n);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disable_ram();
        t_bank_write();
        t_ignored();
        t_ram();
        t_window_and_open();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule